// File: doc/BRIEF.md
# Serial ADC Conversion Controller

This block runs a three-wire read interface to a serial sampling converter. It drives chip select low and issues a fixed number of serial clocks. On each clock it captures the returned bit, then raises chip select again and presents the right-aligned result on a parallel bus with a one-cycle strobe. The frame length follows from the converter resolution: four leading bits plus the data bits, so 16 clocks for 12-bit results and 14 clocks for 10-bit results.

Each interval on the wires is a parameter counted in system clock cycles. These are the power-up wait, the chip-select setup before the first clock, the serial clock low and high phases, and the idle time between frames. An elaboration-time check compares them, through the system clock period parameter, against the converter's limits:

- serial clock between 10 kHz and 5 MHz
- each clock phase at least 40 % of the period
- at least 40 ns from a falling clock edge to the sample
- at least 22 ns from chip select falling to the first sample
- at least 10 ns of setup
- at least 50 ns of quiet time and at least 10 ns of chip-select high time between frames
- at least 1 us after power-up

A conversion starts from a one-cycle start request or continuously while the free-running input is held high.

Top module: `adc_frame_ctrl`

## Requirements
- R1: While reset is high, adc_cs_n_o = 1, adc_sclk_o = 1, sample_valid_o = 0 and sample_o = 0. After reset is released, chip select does not fall before PWRUP_CYC cycles have passed. A start request made during that wait is dropped and does not cause a later frame.
- R2: In idle, a start_i high at a clock edge, or free_run_i high, makes adc_cs_n_o fall at that edge. adc_sclk_o is high whenever adc_cs_n_o is high and toggles only inside a frame.
- R3: adc_cs_n_o is low for exactly SETUP_CYC cycles before the first falling edge of adc_sclk_o.
- R4: Every low phase of adc_sclk_o lasts exactly SCLK_LO_CYC cycles, and every high phase inside a frame lasts exactly SCLK_HI_CYC cycles.
- R5: A frame has exactly RES_BITS + 4 falling edges of adc_sclk_o. adc_cs_n_o rises SCLK_HI_CYC cycles after the last rising edge.
- R6: adc_sdata_i is captured at each rising edge of adc_sclk_o, MSB first, taking the value held during the preceding low phase. The first four captured bits are discarded whatever their value. The last RES_BITS bits appear right-aligned on sample_o.
- R7: sample_valid_o is high for exactly one cycle, in the cycle in which adc_cs_n_o returns high. sample_o changes only in that cycle.
- R8: Between frames, adc_cs_n_o stays high for at least max(QUIET_CYC, CS_HIGH_CYC) + 1 cycles.
- R9: A start request made while a frame or the gap after it is in progress is dropped. No extra frame follows.
- R10: While free_run_i stays high, frames follow back to back, and each chip-select fall comes exactly max(QUIET_CYC, CS_HIGH_CYC) + 1 cycles after the previous rise. Once free_run_i is low, no new frame begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset; its release acts as the power-up request |
| start_i | input | 1 | One-cycle request for a single conversion |
| free_run_i | input | 1 | Convert continuously while high |
| adc_sdata_i | input | 1 | Serial data from the converter |
| adc_cs_n_o | output | 1 | Active-low chip select to the converter |
| adc_sclk_o | output | 1 | Serial clock to the converter, idle high |
| sample_o | output | RES_BITS | Last converted result, right-aligned |
| sample_valid_o | output | 1 | One-cycle strobe marking a new result |

## Verification
The bench drives frames whose leading bits are ones. A design that kept those bits, or that sampled one clock early or late, would return a shifted or corrupted word. It counts the cycles from reset release to the first chip-select fall, and the cycles of every setup, clock phase and gap. An off-by-one counter load would show up as a phase one cycle short, a frame with 15 or 17 clocks, or a chip-select fall during the power-up wait. Start pulses are sent during power-up, mid-frame and inside the gap. A controller that latched them would run an unexpected extra frame and produce a result the scoreboard did not expect. Free-running mode is stopped right after a strobe, which catches a design that lets one more frame slip out.

// File: rtl/adc_frame_pkg.sv
package adc_frame_pkg;

  localparam int LEAD_BITS = 4;

  typedef enum logic [2:0] {
    ST_PWRUP,
    ST_IDLE,
    ST_SETUP,
    ST_LOW,
    ST_HIGH,
    ST_GAP
  } ctrl_state_e;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/adc_interval_timer.sv
module adc_interval_timer #(
  parameter int W       = 8,
  parameter int RST_VAL = 0
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         zero_o
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cnt_q <= W'(RST_VAL);
    end else if (load_i) begin
      cnt_q <= load_val_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/adc_bit_shifter.sv
module adc_bit_shifter #(
  parameter int W = 12
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic         shift_i,
  input  logic         din_i,
  output logic [W-1:0] q_o
);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      q_o <= '0;
    end else if (shift_i) begin
      q_o <= {q_o[W-2:0], din_i};
    end
  end

endmodule

// File: rtl/adc_frame_ctrl.sv
module adc_frame_ctrl
  import adc_frame_pkg::*;
#(
  parameter int RES_BITS    = 12,
  parameter int SYS_CLK_NS  = 4,
  parameter int SCLK_LO_CYC = 25,
  parameter int SCLK_HI_CYC = 25,
  parameter int SETUP_CYC   = 3,
  parameter int QUIET_CYC   = 13,
  parameter int CS_HIGH_CYC = 3,
  parameter int PWRUP_CYC   = 250
) (
  input  logic                clk_i,
  input  logic                rst_i,
  input  logic                start_i,
  input  logic                free_run_i,
  input  logic                adc_sdata_i,
  output logic                adc_cs_n_o,
  output logic                adc_sclk_o,
  output logic [RES_BITS-1:0] sample_o,
  output logic                sample_valid_o
);

  localparam int FRAME_CLKS = RES_BITS + LEAD_BITS;
  localparam int GAP_CYC    = max2(QUIET_CYC, CS_HIGH_CYC);
  localparam int PERIOD_CYC = SCLK_LO_CYC + SCLK_HI_CYC;
  localparam int TW = $clog2(PWRUP_CYC + GAP_CYC + SETUP_CYC + PERIOD_CYC + 1);
  localparam int BW = $clog2(FRAME_CLKS);

  // Limits checked at elaboration time
  if (RES_BITS != 12 && RES_BITS != 10) begin : g_bad_res
    $error("adc_frame_ctrl: resolution must be 10 or 12");
  end
  if (PERIOD_CYC * SYS_CLK_NS < 200 || PERIOD_CYC * SYS_CLK_NS > 100000) begin : g_bad_freq
    $error("adc_frame_ctrl: serial clock outside 10 kHz .. 5 MHz");
  end
  if (SCLK_LO_CYC * 10 < PERIOD_CYC * 4 || SCLK_HI_CYC * 10 < PERIOD_CYC * 4) begin : g_bad_duty
    $error("adc_frame_ctrl: serial clock duty outside 40/60");
  end
  if (SCLK_LO_CYC * SYS_CLK_NS < 40) begin : g_bad_access
    $error("adc_frame_ctrl: low phase shorter than data access time");
  end
  if (SETUP_CYC < 1 || SETUP_CYC * SYS_CLK_NS < 10 ||
      (SETUP_CYC + SCLK_LO_CYC) * SYS_CLK_NS < 22) begin : g_bad_setup
    $error("adc_frame_ctrl: chip select setup too short");
  end
  if (QUIET_CYC * SYS_CLK_NS < 50 || CS_HIGH_CYC * SYS_CLK_NS < 10) begin : g_bad_gap
    $error("adc_frame_ctrl: inter-frame gap too short");
  end
  if (PWRUP_CYC * SYS_CLK_NS < 1000) begin : g_bad_pwrup
    $error("adc_frame_ctrl: power-up wait shorter than 1 us");
  end

  ctrl_state_e          st_q, st_d;
  logic                 cs_q, cs_d;
  logic                 sclk_q, sclk_d;
  logic [BW-1:0]        bit_q, bit_d;
  logic                 vld_q, vld_d;
  logic [RES_BITS-1:0]  smp_q;
  logic [RES_BITS-1:0]  shift_q;
  logic                 shift_en;
  logic                 t_ld;
  logic [TW-1:0]        t_val;
  logic                 t_zero;

  adc_interval_timer #(
    .W       (TW),
    .RST_VAL (PWRUP_CYC - 1)
  ) u_timer (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .load_i     (t_ld),
    .load_val_i (t_val),
    .zero_o     (t_zero)
  );

  adc_bit_shifter #(
    .W (RES_BITS)
  ) u_shift (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .shift_i (shift_en),
    .din_i   (adc_sdata_i),
    .q_o     (shift_q)
  );

  always_comb begin
    st_d     = st_q;
    cs_d     = cs_q;
    sclk_d   = sclk_q;
    bit_d    = bit_q;
    vld_d    = 1'b0;
    shift_en = 1'b0;
    t_ld     = 1'b0;
    t_val    = '0;
    case (st_q)
      ST_PWRUP: if (t_zero) st_d = ST_IDLE;
      ST_IDLE: if (start_i || free_run_i) begin
        st_d  = ST_SETUP;
        cs_d  = 1'b0;
        t_ld  = 1'b1;
        t_val = TW'(SETUP_CYC - 1);
      end
      ST_SETUP: if (t_zero) begin
        st_d   = ST_LOW;
        sclk_d = 1'b0;
        t_ld   = 1'b1;
        t_val  = TW'(SCLK_LO_CYC - 1);
      end
      ST_LOW: if (t_zero) begin
        st_d     = ST_HIGH;
        sclk_d   = 1'b1;
        shift_en = 1'b1;
        t_ld     = 1'b1;
        t_val    = TW'(SCLK_HI_CYC - 1);
      end
      ST_HIGH: if (t_zero) begin
        t_ld = 1'b1;
        if (bit_q == BW'(FRAME_CLKS - 1)) begin
          st_d  = ST_GAP;
          cs_d  = 1'b1;
          vld_d = 1'b1;
          bit_d = '0;
          t_val = TW'(GAP_CYC - 1);
        end else begin
          st_d   = ST_LOW;
          sclk_d = 1'b0;
          bit_d  = bit_q + 1'b1;
          t_val  = TW'(SCLK_LO_CYC - 1);
        end
      end
      ST_GAP: if (t_zero) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      st_q   <= ST_PWRUP;
      cs_q   <= 1'b1;
      sclk_q <= 1'b1;
      bit_q  <= '0;
      vld_q  <= 1'b0;
      smp_q  <= '0;
    end else begin
      st_q   <= st_d;
      cs_q   <= cs_d;
      sclk_q <= sclk_d;
      bit_q  <= bit_d;
      vld_q  <= vld_d;
      if (vld_d) smp_q <= shift_q;
    end
  end

  assign adc_cs_n_o     = cs_q;
  assign adc_sclk_o     = sclk_q;
  assign sample_o       = smp_q;
  assign sample_valid_o = vld_q;

endmodule

// File: rtl/adc_frame_ctrl_chk.sv
module adc_frame_ctrl_chk #(
  parameter int RES_BITS = 12,
  parameter int LO_CYC   = 25,
  parameter int HI_CYC   = 25
) (
  input logic                clk,
  input logic                rst,
  input logic                cs_n,
  input logic                sclk,
  input logic                valid,
  input logic [RES_BITS-1:0] sample
);

  logic [15:0] lo_cnt, hi_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_cnt <= '0;
      hi_cnt <= '0;
    end else if (!sclk) begin
      hi_cnt <= '0;
      if (lo_cnt != 16'hFFFF) lo_cnt <= lo_cnt + 1'b1;
    end else begin
      lo_cnt <= '0;
      if (hi_cnt != 16'hFFFF) hi_cnt <= hi_cnt + 1'b1;
    end
  end

  AST_SCLK_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst) cs_n |-> sclk); // R2
  AST_CS_BEFORE_SCLK: assert property (@(posedge clk) disable iff (rst) $fell(sclk) |-> !cs_n); // R3
  AST_LOW_PHASE_MIN: assert property (@(posedge clk) disable iff (rst) $rose(sclk) |-> (lo_cnt >= 16'(LO_CYC))); // R4
  AST_HIGH_PHASE_MIN: assert property (@(posedge clk) disable iff (rst) $fell(sclk) |-> (hi_cnt >= 16'(HI_CYC))); // R4
  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst) valid |=> !valid); // R7
  AST_VALID_AT_CS_RISE: assert property (@(posedge clk) disable iff (rst) valid |-> $rose(cs_n)); // R7
  AST_SAMPLE_HOLD: assert property (@(posedge clk) disable iff (rst) !valid |-> $stable(sample)); // R7

endmodule

bind adc_frame_ctrl adc_frame_ctrl_chk #(
  .RES_BITS (RES_BITS),
  .LO_CYC   (SCLK_LO_CYC),
  .HI_CYC   (SCLK_HI_CYC)
) u_chk (
  .clk    (clk_i),
  .rst    (rst_i),
  .cs_n   (adc_cs_n_o),
  .sclk   (adc_sclk_o),
  .valid  (sample_valid_o),
  .sample (sample_o)
);

// File: tb/test_adc_frame_ctrl.sv
module test_adc_frame_ctrl;

  localparam int RES   = 12;
  localparam int LO    = 25;
  localparam int HI    = 25;
  localparam int SETUP = 3;
  localparam int QUIET = 13;
  localparam int CSHI  = 3;
  localparam int PWR   = 250;
  localparam int GAP   = (QUIET > CSHI) ? QUIET : CSHI;
  localparam int FRAME = RES + 4;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0, free_run = 1'b0, sdata = 1'b0;
  logic cs_n, sclk, valid;
  logic [RES-1:0] sample;

  always #2 clk = ~clk;

  adc_frame_ctrl #(
    .RES_BITS (RES), .SYS_CLK_NS (4), .SCLK_LO_CYC (LO), .SCLK_HI_CYC (HI),
    .SETUP_CYC (SETUP), .QUIET_CYC (QUIET), .CS_HIGH_CYC (CSHI), .PWRUP_CYC (PWR)
  ) i_adc_frame_ctrl (
    .clk_i (clk), .rst_i (rst), .start_i (start), .free_run_i (free_run),
    .adc_sdata_i (sdata), .adc_cs_n_o (cs_n), .adc_sclk_o (sclk),
    .sample_o (sample), .sample_valid_o (valid)
  );

  int checks = 0, errors = 0;
  logic [RES-1:0] exp_q[$];
  logic [FRAME-1:0] adc_word = '0;
  int fall_k = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Converter model: next bit appears after every falling serial clock edge
  always @(negedge cs_n) fall_k = 0;
  always @(negedge sclk) begin
    if (cs_n === 1'b0 && fall_k < FRAME) begin
      sdata = adc_word[FRAME-1-fall_k];
      fall_k++;
    end
  end

  // Monitor and scoreboard, sampled 1 ns after each rising clock edge
  int cyc = 0, t_rst = 0, t_csfall = 0, t_csrise = 0, t_sfall = 0, t_srise = 0, nfall = 0;
  bit rst_seen = 0, had_frame = 0, fr_rise = 0;
  logic p_cs = 1'b1, p_sclk = 1'b1;
  logic [RES-1:0] p_sample = '0;

  always @(posedge clk) begin
    #1;
    cyc++;
    if (rst) begin
      check(cs_n === 1'b1 && sclk === 1'b1, "R1", "reset cs_n/sclk", {cs_n, sclk}, 3);
      check(valid === 1'b0, "R1", "reset valid", valid, 0);
      check(sample === '0, "R1", "reset sample", int'(sample), 0);
    end else begin
      if (!rst_seen) begin rst_seen = 1; t_rst = cyc; end
      check(!(cs_n && !sclk), "R2", "sclk low while cs_n high", sclk, 1);
      if (p_cs && !cs_n) begin
        if (!had_frame)
          check(cyc - t_rst >= PWR, "R1", "cycles to first cs fall", cyc - t_rst, PWR);
        else begin
          check(cyc - t_csrise >= GAP + 1, "R8", "cs_n high gap", cyc - t_csrise, GAP + 1);
          if (fr_rise && free_run)
            check(cyc - t_csrise == GAP + 1, "R10", "free-run gap", cyc - t_csrise, GAP + 1);
        end
        t_csfall = cyc; nfall = 0; had_frame = 1;
      end
      if (p_sclk && !sclk) begin
        if (nfall == 0)
          check(cyc - t_csfall == SETUP, "R3", "cs setup", cyc - t_csfall, SETUP);
        else
          check(cyc - t_srise == HI, "R4", "high phase", cyc - t_srise, HI);
        nfall++; t_sfall = cyc;
      end
      if (!p_sclk && sclk) begin
        check(cyc - t_sfall == LO, "R4", "low phase", cyc - t_sfall, LO);
        t_srise = cyc;
      end
      if (!p_cs && cs_n) begin
        check(nfall == FRAME, "R5", "falling edges per frame", nfall, FRAME);
        check(cyc - t_srise == HI, "R5", "last rise to cs rise", cyc - t_srise, HI);
        check(valid === 1'b1, "R7", "valid at cs rise", valid, 1);
        t_csrise = cyc; fr_rise = free_run;
      end
      if (valid) begin
        check(!p_cs && cs_n, "R7", "valid without cs rise", cs_n, 1);
        if (exp_q.size() == 0)
          check(0, "R9", "unexpected result", int'(sample), -1);
        else begin
          logic [RES-1:0] e;
          e = exp_q.pop_front();
          check(sample === e, "R6", "result word", int'(sample), int'(e));
        end
      end else begin
        check(sample === p_sample, "R7", "sample changed without valid", int'(sample), int'(p_sample));
      end
    end
    p_cs = cs_n; p_sclk = sclk; p_sample = sample;
  end

  task automatic pulse_start();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_valid();
    do @(negedge clk); while (valid !== 1'b1);
  endtask

  task automatic run_frame(input logic [RES-1:0] v, input logic [3:0] lead);
    adc_word = {lead, v};
    exp_q.push_back(v);
    @(negedge clk);
    pulse_start();
    wait_valid();
    repeat (GAP + 2) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R5 watchdog expired: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    // R1: start requests during the power-up wait are dropped
    repeat (10) @(negedge clk);
    pulse_start();
    repeat (100) @(negedge clk);
    pulse_start();
    repeat (PWR) @(negedge clk);
    check(cs_n === 1'b1, "R1", "frame after start during power-up", cs_n, 1);

    // R6: words of different patterns, leading bits non-zero to prove discard
    run_frame(12'hFFF, 4'b0000);
    run_frame(12'h000, 4'b1111);
    run_frame(12'hA5C, 4'b1010);
    run_frame(12'h001, 4'b0101);
    run_frame(12'h800, 4'b1111);

    // R9: start mid-frame and inside the gap is dropped
    adc_word = {4'b1001, 12'h5A5};
    exp_q.push_back(12'h5A5);
    pulse_start();
    while (cs_n !== 1'b0) @(negedge clk);
    repeat (40) @(negedge clk);
    pulse_start();
    wait_valid();
    repeat (3) @(negedge clk);
    pulse_start();
    repeat (200) @(negedge clk);
    check(cs_n === 1'b1, "R9", "cs_n after ignored starts", cs_n, 1);
    check(exp_q.size() == 0, "R9", "pending results", exp_q.size(), 0);

    // R10: free-running frames, stopped right after the third strobe
    adc_word = {4'b1100, 12'h3C3};
    repeat (3) exp_q.push_back(12'h3C3);
    free_run = 1'b1;
    repeat (3) wait_valid();
    free_run = 1'b0;
    repeat (200) @(negedge clk);
    check(cs_n === 1'b1, "R10", "cs_n after free-run stop", cs_n, 1);
    check(exp_q.size() == 0, "R10", "pending free-run results", exp_q.size(), 0);

    finish_run();
  end

endmodule